// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block turns a parallel write request into the pin activity needed by a three-wire, double-buffered serial DAC. A request carries a 12-bit code and a clear flag and is taken with a valid/ready handshake. For a write, the block lowers chip select and shifts the code out most significant bit first on rising serial clock edges. It then raises chip select and pulses the active-low load strobe, which moves the shifted word into the converter's output register. For a clear, it drives only an active-low clear pulse and leaves the serial pins idle.

Every interval is a whole number of system clock cycles. Each one is derived by ceiling division from a nanosecond limit and the clock period, both given as parameters. This means the converter's minimum pulse widths, setup times and hold times are met for any clock rate chosen at build time. Ready is high only while the sequencer is idle, so a request arriving mid-frame waits.

Top module: `sdac_wr_ctrl`

## Requirements
- R1: During reset and in the first idle cycles after it, chip select, load strobe and clear are high, the serial clock is low, and ready is high.
- R2: A write request (clear flag 0) produces exactly 12 rising serial clock edges. The bit on the serial data pin at each rising edge, taken most significant first, equals the requested code. A converter model that latches the word while the load strobe is low then holds that code.
- R3: The serial clock stays high for at least ceil(T_CLK_HI_NS/CLK_PERIOD_NS) cycles and low for at least ceil(T_CLK_LO_NS/CLK_PERIOD_NS) cycles at each level change inside a frame.
- R4: Serial data is unchanged for at least ceil(T_DS_NS/CLK_PERIOD_NS) cycles before each rising edge. It does not change earlier than ceil(T_DH_NS/CLK_PERIOD_NS) cycles after that edge, and it never changes while the serial clock is high.
- R5: The serial clock is high only while chip select is low. Chip select is low for at least ceil(T_CSS_NS/CLK_PERIOD_NS) cycles before the first rising edge, and it stays low for at least ceil(T_CSH_NS/CLK_PERIOD_NS) cycles after the last rising edge.
- R6: Each write yields exactly one load strobe pulse. The pulse starts at least ceil(T_LD_SETUP_NS/CLK_PERIOD_NS) cycles after the twelfth rising edge and lasts at least ceil(T_LDW_NS/CLK_PERIOD_NS) cycles.
- R7: The serial clock is never high while the load strobe is low. After the strobe rises, at least ceil(T_LD_REC_NS/CLK_PERIOD_NS) cycles pass before chip select falls for the next frame.
- R8: Ready is high only when all pins are idle, and a request is taken only on a cycle with valid and ready both high. Code, clear flag and valid activity while ready is low have no effect on the frame in progress.
- R9: A request with the clear flag set produces one clear pulse of at least ceil(T_CLR_NS/CLK_PERIOD_NS) cycles. It produces no serial clock edge and no load strobe, the code field is ignored, and the converter model then holds zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_code | input | DATA_W | Code to send (12 bits by default) |
| req_clear | input | 1 | 1: issue clear pulse only; 0: write req_code |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_sclk | output | 1 | Serial clock, data taken on rising edge |
| dac_sdi | output | 1 | Serial data, MSB first |
| dac_ld_n | output | 1 | Load strobe to the output register, active low |
| dac_clr_n | output | 1 | Clear to zero, active low |

## Verification
The write command and the clear command share one request word, so both can be asked for in the same cycle. The bench provokes this with requests that carry the clear flag together with a nonzero code, including all-ones. The outcome counts as correct only if the frame shows one clear pulse, no clock edge, no load strobe and a converter model at zero, with the next write still landing intact. A second overlap is a new request held valid while a frame is still running. The bench judges it by the captured word of the running frame and by the recovery gap before the next chip select.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_CLR        = 4'd1,
    ST_CS_SETUP   = 4'd2,
    ST_SHIFT_LO   = 4'd3,
    ST_SHIFT_HI   = 4'd4,
    ST_CS_HOLD    = 4'd5,
    ST_LD_SETUP   = 4'd6,
    ST_LD_PULSE   = 4'd7,
    ST_LD_RECOVER = 4'd8
  } sdac_state_e;

  // nanoseconds to clock cycles, rounded up, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdac_interval_timer.sv
module sdac_interval_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdac_bit_shifter.sv
module sdac_bit_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb,
  output logic         last_bit
);

  localparam int BW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sreg_q;
  logic [W-1:0]  sreg_d;
  logic [BW-1:0] bcnt_q;
  logic [BW-1:0] bcnt_d;
  logic          en;

  always_comb begin
    en     = load || shift;
    sreg_d = load ? load_val : {sreg_q[W-2:0], 1'b0};
    bcnt_d = load ? '0 : (bcnt_q + BW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      bcnt_q <= '0;
    end else if (en) begin
      sreg_q <= sreg_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign msb      = sreg_q[W-1];
  assign last_bit = (bcnt_q == BW'(W-1));

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (bcnt_q <= BW'(W-1)));  // R2

endmodule

// File: rtl/sdac_seq_fsm.sv
module sdac_seq_fsm
  import sdac_pkg::*;
#(
  parameter int TW      = 4,
  parameter int CSS_CYC = 4,
  parameter int LO_CYC  = 4,
  parameter int HI_CYC  = 4,
  parameter int CSH_CYC = 4,
  parameter int LD1_CYC = 2,
  parameter int LDW_CYC = 4,
  parameter int REC_CYC = 4,
  parameter int CLR_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_clear,
  input  logic          tmr_expired,
  input  logic          last_bit,
  input  logic          sdi,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          sh_load,
  output logic          sh_shift,
  output logic          ready,
  output logic          cs_n,
  output logic          sclk,
  output logic          ld_n,
  output logic          clr_n
);

  localparam logic [TW-1:0] V_CSS = TW'(CSS_CYC - 1);
  localparam logic [TW-1:0] V_LO  = TW'(LO_CYC - 1);
  localparam logic [TW-1:0] V_HI  = TW'(HI_CYC - 1);
  localparam logic [TW-1:0] V_CSH = TW'(CSH_CYC - 1);
  localparam logic [TW-1:0] V_LD1 = TW'(LD1_CYC - 1);
  localparam logic [TW-1:0] V_LDW = TW'(LDW_CYC - 1);
  localparam logic [TW-1:0] V_REC = TW'(REC_CYC - 1);
  localparam logic [TW-1:0] V_CLR = TW'(CLR_CYC - 1);

  sdac_state_e state_q, state_d;
  logic        state_chg;
  logic        ready_q, cs_n_q, sclk_q, ld_n_q, clr_n_q;
  logic        ready_d, cs_n_d, sclk_d, ld_n_d, clr_n_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (req_valid)   state_d = req_clear ? ST_CLR : ST_CS_SETUP;
      ST_CLR:        if (tmr_expired) state_d = ST_IDLE;
      ST_CS_SETUP:   if (tmr_expired) state_d = ST_SHIFT_LO;
      ST_SHIFT_LO:   if (tmr_expired) state_d = ST_SHIFT_HI;
      ST_SHIFT_HI:   if (tmr_expired) state_d = last_bit ? ST_CS_HOLD : ST_SHIFT_LO;
      ST_CS_HOLD:    if (tmr_expired) state_d = ST_LD_SETUP;
      ST_LD_SETUP:   if (tmr_expired) state_d = ST_LD_PULSE;
      ST_LD_PULSE:   if (tmr_expired) state_d = ST_LD_RECOVER;
      ST_LD_RECOVER: if (tmr_expired) state_d = ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  // interval selection for the state being entered
  always_comb begin
    unique case (state_d)
      ST_CLR:        tmr_val = V_CLR;
      ST_CS_SETUP:   tmr_val = V_CSS;
      ST_SHIFT_LO:   tmr_val = V_LO;
      ST_SHIFT_HI:   tmr_val = V_HI;
      ST_CS_HOLD:    tmr_val = V_CSH;
      ST_LD_SETUP:   tmr_val = V_LD1;
      ST_LD_PULSE:   tmr_val = V_LDW;
      ST_LD_RECOVER: tmr_val = V_REC;
      default:       tmr_val = '0;
    endcase
  end

  always_comb begin
    state_chg = (state_d != state_q);
    tmr_load  = state_chg;
    sh_load   = (state_q == ST_IDLE) && req_valid && !req_clear;
    sh_shift  = (state_q == ST_SHIFT_HI) && tmr_expired;
    ready_d   = (state_d == ST_IDLE);
    cs_n_d    = !((state_d == ST_CS_SETUP) || (state_d == ST_SHIFT_LO) ||
                  (state_d == ST_SHIFT_HI) || (state_d == ST_CS_HOLD));
    sclk_d    = (state_d == ST_SHIFT_HI);
    ld_n_d    = (state_d != ST_LD_PULSE);
    clr_n_d   = (state_d != ST_CLR);
  end

  // state and registered pin drivers, updated only on a state change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b1;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      ld_n_q  <= 1'b1;
      clr_n_q <= 1'b1;
    end else if (state_chg) begin
      state_q <= state_d;
      ready_q <= ready_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      ld_n_q  <= ld_n_d;
      clr_n_q <= clr_n_d;
    end
  end

  assign ready = ready_q;
  assign cs_n  = cs_n_q;
  assign sclk  = sclk_q;
  assign ld_n  = ld_n_q;
  assign clr_n = clr_n_q;

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> !cs_n_q);  // R5
  AST_SDI_STABLE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(sdi));  // R4
  AST_NO_SCLK_IN_LD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n_q |-> (!sclk_q && cs_n_q));  // R7
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> (cs_n_q && ld_n_q && clr_n_q && !sclk_q));  // R8
  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_q |-> (cs_n_q && ld_n_q && !sclk_q));  // R9
  AST_LD_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_n_q) |-> $past(state_q == ST_LD_SETUP));  // R6

endmodule

// File: rtl/sdac_wr_ctrl.sv
module sdac_wr_ctrl
  import sdac_pkg::*;
#(
  parameter int DATA_W         = 12,
  parameter int CLK_PERIOD_NS  = 8,
  parameter int T_CLK_HI_NS    = 30,
  parameter int T_CLK_LO_NS    = 30,
  parameter int T_DS_NS        = 15,
  parameter int T_DH_NS        = 15,
  parameter int T_CSS_NS       = 30,
  parameter int T_CSH_NS       = 30,
  parameter int T_LD_SETUP_NS  = 15,
  parameter int T_LDW_NS       = 30,
  parameter int T_LD_REC_NS    = 30,
  parameter int T_CLR_NS       = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_code,
  input  logic              req_clear,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdi,
  output logic              dac_ld_n,
  output logic              dac_clr_n
);

  localparam int CSS_CYC = ns_to_cyc(T_CSS_NS, CLK_PERIOD_NS);
  localparam int LO_CYC  = max_of(ns_to_cyc(T_CLK_LO_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(T_DS_NS, CLK_PERIOD_NS));
  localparam int HI_CYC  = max_of(ns_to_cyc(T_CLK_HI_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(T_DH_NS, CLK_PERIOD_NS));
  localparam int CSH_CYC = ns_to_cyc(T_CSH_NS, CLK_PERIOD_NS);
  localparam int LD1_CYC = ns_to_cyc(T_LD_SETUP_NS, CLK_PERIOD_NS);
  localparam int LDW_CYC = ns_to_cyc(T_LDW_NS, CLK_PERIOD_NS);
  localparam int REC_CYC = ns_to_cyc(T_LD_REC_NS, CLK_PERIOD_NS);
  localparam int CLR_CYC = ns_to_cyc(T_CLR_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC = max_of(max_of(max_of(CSS_CYC, LO_CYC), max_of(HI_CYC, CSH_CYC)),
                                  max_of(max_of(LD1_CYC, LDW_CYC), max_of(REC_CYC, CLR_CYC)));
  localparam int TW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          sh_load, sh_shift, sh_msb, sh_last;

  sdac_interval_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sdac_bit_shifter #(.W(DATA_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (sh_load),
    .load_val (req_code),
    .shift    (sh_shift),
    .msb      (sh_msb),
    .last_bit (sh_last)
  );

  sdac_seq_fsm #(
    .TW(TW), .CSS_CYC(CSS_CYC), .LO_CYC(LO_CYC), .HI_CYC(HI_CYC),
    .CSH_CYC(CSH_CYC), .LD1_CYC(LD1_CYC), .LDW_CYC(LDW_CYC),
    .REC_CYC(REC_CYC), .CLR_CYC(CLR_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .req_clear   (req_clear),
    .tmr_expired (tmr_expired),
    .last_bit    (sh_last),
    .sdi         (sh_msb),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .sh_load     (sh_load),
    .sh_shift    (sh_shift),
    .ready       (req_ready),
    .cs_n        (dac_cs_n),
    .sclk        (dac_sclk),
    .ld_n        (dac_ld_n),
    .clr_n       (dac_clr_n)
  );

  assign dac_sdi = sh_msb;

endmodule

// File: tb/sdac_wr_ctrl_tb.sv
module sdac_wr_ctrl_tb;

  localparam int PER = 8;

  function automatic int cyc(input int ns);
    return (ns + PER - 1) / PER;
  endfunction

  localparam int E_HI  = 4;   // ceil(30/8)
  localparam int E_LO  = 4;
  localparam int E_DS  = 2;   // ceil(15/8)
  localparam int E_DH  = 2;
  localparam int E_CSS = 4;
  localparam int E_CSH = 4;
  localparam int E_LD1 = 2;
  localparam int E_LDW = 4;
  localparam int E_REC = 4;
  localparam int E_CLR = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_clear;
  logic [11:0] req_code;
  logic dac_cs_n, dac_sclk, dac_sdi, dac_ld_n, dac_clr_n;

  always #(PER/2) clk = ~clk;

  sdac_wr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .req_clear(req_clear), .dac_cs_n(dac_cs_n),
    .dac_sclk(dac_sclk), .dac_sdi(dac_sdi), .dac_ld_n(dac_ld_n), .dac_clr_n(dac_clr_n)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // pin monitor state
  bit   mon_en = 0;
  int   cycles = 0;
  bit   p_sclk, p_sdi, p_cs_n, p_ld_n, p_clr_n;
  int   sclk_run, sdi_run, cs_low_run, ld_run, clr_run;
  int   since_rise, since_ld_rise;
  bit   had_rise, ld_seen;
  bit   frame_open;
  int   age, bits, rises, lds, clrs, v_ld_sclk, v_ready;
  logic [11:0] cap, exp_code, dac_model;
  bit   exp_clr;

  task automatic close_frame();
    if (exp_clr) begin
      chk(rises == 0, "R9 clock edges in clear", rises, 0);
      chk(lds == 0,   "R9 load strobes in clear", lds, 0);
      chk(clrs == 1,  "R9 clear pulses", clrs, 1);
      chk(dac_model == 12'h000, "R9 model after clear", dac_model, 0);
    end else begin
      chk(rises == 12, "R2 rising edges", rises, 12);
      chk(cap == exp_code, "R2 shifted word", cap, exp_code);
      chk(lds == 1,  "R6 load strobes", lds, 1);
      chk(clrs == 0, "R2 no clear in write", clrs, 0);
      chk(dac_model == exp_code, "R2 model after write", dac_model, exp_code);
    end
    chk(v_ld_sclk == 0, "R7 clock high under load", v_ld_sclk, 0);
    chk(v_ready == 0,   "R8 ready with active pins", v_ready, 0);
    frame_open = 0;
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      cycles++;
      if (cycles > 150000) begin
        chk(0, "watchdog", cycles, 150000);
        summary();
      end
      if (frame_open) age++;
      if (frame_open && age >= 1 && req_ready) close_frame();

      if (had_rise) since_rise++;
      if (ld_seen) since_ld_rise++;

      // serial data
      if (dac_sdi != p_sdi) begin
        if (!dac_cs_n && had_rise && bits > 0)
          chk(since_rise >= E_DH, "R4 hold after rise", since_rise, E_DH);
        chk(!(dac_sclk && p_sclk), "R4 data change while clock high", 1, 0);
        sdi_run = 1;
      end else sdi_run++;

      // serial clock
      if (dac_sclk != p_sclk) begin
        if (dac_sclk) begin
          chk(sclk_run >= E_LO, "R3 clock low time", sclk_run, E_LO);
          chk(sdi_run > E_DS, "R4 setup before rise", sdi_run - 1, E_DS);
          chk(!dac_cs_n, "R5 chip select at rise", dac_cs_n, 0);
          if (bits == 0)
            chk(cs_low_run >= E_CSS, "R5 select setup", cs_low_run, E_CSS);
          cap = {cap[10:0], dac_sdi};
          bits++; rises++;
          since_rise = 0; had_rise = 1;
        end else begin
          chk(sclk_run >= E_HI, "R3 clock high time", sclk_run, E_HI);
        end
        sclk_run = 1;
      end else sclk_run++;

      // chip select
      if (!dac_cs_n && p_cs_n && ld_seen)
        chk(since_ld_rise >= E_REC, "R7 recovery before select", since_ld_rise, E_REC);
      if (dac_cs_n && !p_cs_n && had_rise)
        chk(since_rise >= E_CSH, "R5 select hold", since_rise, E_CSH);
      if (!dac_cs_n) cs_low_run++; else cs_low_run = 0;

      // load strobe
      if (!dac_ld_n && p_ld_n) begin
        chk(since_rise >= E_LD1 && bits == 12, "R6 strobe after last edge", since_rise, E_LD1);
        lds++; ld_run = 0;
      end
      if (!dac_ld_n) begin
        ld_run++;
        dac_model = cap;
        if (dac_sclk) v_ld_sclk++;
      end
      if (dac_ld_n && !p_ld_n) begin
        chk(ld_run >= E_LDW, "R6 strobe width", ld_run, E_LDW);
        since_ld_rise = 0; ld_seen = 1;
      end

      // clear
      if (!dac_clr_n && p_clr_n) begin clrs++; clr_run = 0; end
      if (!dac_clr_n) begin clr_run++; dac_model = 12'h000; end
      if (dac_clr_n && !p_clr_n)
        chk(clr_run >= E_CLR, "R9 clear width", clr_run, E_CLR);

      if (req_ready && (!dac_cs_n || !dac_ld_n || !dac_clr_n || dac_sclk)) v_ready++;

      // request taken at the coming edge
      if (req_valid && req_ready) begin
        frame_open = 1; age = 0;
        exp_code = req_code; exp_clr = req_clear;
        bits = 0; rises = 0; lds = 0; clrs = 0; v_ld_sclk = 0; v_ready = 0;
        cap = '0; had_rise = 0;
      end

      p_sclk = dac_sclk; p_sdi = dac_sdi; p_cs_n = dac_cs_n;
      p_ld_n = dac_ld_n; p_clr_n = dac_clr_n;
    end
  end

  // inputs change one unit after a rising edge
  task automatic send(input logic [11:0] code, input bit clr);
    @(posedge clk); #1;
    req_valid = 1; req_code = code; req_clear = clr;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
    req_code  = ~code;       // R8: noise while busy
    req_clear = ~clr;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
  endtask

  task automatic send_pair(input logic [11:0] c1, input logic [11:0] c2);
    @(posedge clk); #1;
    req_valid = 1; req_code = c1; req_clear = 0;
    forever begin @(negedge clk); if (req_ready) break; end
    @(posedge clk); #1;
    req_code = c2;           // R8: held valid while busy
    forever begin @(negedge clk); if (req_ready) break; end
    @(posedge clk); #1;
    req_valid = 0;
    forever begin @(negedge clk); if (req_ready) break; end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; req_valid = 0; req_code = '0; req_clear = 0;
    dac_model = '0; cap = '0; exp_code = '0; exp_clr = 0;
    repeat (3) @(negedge clk);
    chk(dac_cs_n && dac_ld_n && dac_clr_n && !dac_sclk, "R1 pins in reset", dac_sclk, 0);
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    @(posedge clk); #1; rst_n = 1;
    repeat (4) @(negedge clk);
    chk(dac_cs_n && dac_ld_n && dac_clr_n && !dac_sclk, "R1 pins after reset", dac_sclk, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    p_sclk = dac_sclk; p_sdi = dac_sdi; p_cs_n = dac_cs_n;
    p_ld_n = dac_ld_n; p_clr_n = dac_clr_n;
    sclk_run = 10; sdi_run = 10; cs_low_run = 0; ld_run = 0; clr_run = 0;
    since_rise = 0; since_ld_rise = 0; had_rise = 0; ld_seen = 0; frame_open = 0;
    mon_en = 1;

    send(12'hFFF, 0);
    send(12'h000, 0);
    send(12'h800, 0);
    send(12'h7FF, 0);
    send(12'hFFF, 1);        // R9: clear with a full code
    send(12'hA5C, 0);
    send_pair(12'h123, 12'hEDC);
    send(12'h001, 1);
    send(12'h001, 1);        // clear twice in a row
    send(12'hAAA, 0);
    for (int i = 0; i < 40; i++) begin
      send(12'($urandom), ($urandom % 5) == 0);
    end
    repeat (4) @(negedge clk);
    if (frame_open) close_frame();
    chk(dac_cs_n && dac_ld_n && dac_clr_n && !dac_sclk && req_ready, "R8 idle at end", req_ready, 1);
    summary();
  end

endmodule